// File: doc/BRIEF.md
# PTP Timestamp Snapshot Filter

This block sits beside a network port's timestamp counter and decides, for every PTP message that the port receives or sends, whether that message's timestamp must be kept. A parser upstream produces a one-cycle strobe together with the 4-bit messageType nibble of the header. The block classifies the nibble and compares it against a mode table. Three configuration inputs drive that table: a 2-bit clock-kind select, a master-role bit and an event-only bit. When the message qualifies, the current counter value and the message code are latched into a capture register.

A latched capture is presented with a valid flag that stays high until a consumer pulses the acknowledge input. A qualifying message that arrives while the register is still occupied does not overwrite it. It sets a sticky overflow flag instead, and that flag is cleared by the same acknowledge. Configuration inputs are examined only on the strobe edge, so a mode change takes effect from the next message.

Top module: `ptp_snap_filter`

## Requirements
- R1: After reset, cap_vld and cap_ovf are low.
- R2: With sel=0 and event_only=0, codes SYNC (0x0), Delay_Req (0x1), Follow_Up (0x8) and Delay_Resp (0x9) are captured, whatever the master bit; no other code is.
- R3: With sel=0 and event_only=1, only SYNC (0x0) is captured when master=0, and only Delay_Req (0x1) when master=1.
- R4: With sel=1 and event_only=0, all seven codes are captured: 0x0, 0x1, 0x2 (Pdelay_Req), 0x3 (Pdelay_Resp), 0x8, 0x9 and 0xA (Pdelay_Resp_Follow_Up).
- R5: With sel=1 and event_only=1, codes 0x2 and 0x3 are captured, plus 0x0 when master=0 or 0x1 when master=1.
- R6: With sel=2, only 0x0 and 0x1 are captured; with sel=3, only 0x2 and 0x3. In both cases master and event_only have no effect.
- R7: Codes 0x4-0x7 and 0xB-0xF never cause a capture in any mode.
- R8: A capture makes cap_ts equal to ts_in and cap_type equal to msg_type, both as sampled on the strobe edge. cap_vld is high from the following cycle.
- R9: While cap_vld is high and cap_ack is low, cap_vld, cap_ts and cap_type hold. An acknowledge with no qualifying strobe clears cap_vld and cap_ovf on the next edge.
- R10: A qualifying strobe while a capture is pending leaves the capture unchanged and sets cap_ovf. A non-qualifying strobe leaves cap_ovf unchanged.
- R11: A qualifying strobe in the same cycle as an acknowledge loads the new capture and leaves cap_ovf low.
- R12: Configuration is used only on a strobe edge. Changing it without a strobe neither creates nor removes a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_vld | input | 1 | One-cycle strobe marking a parsed message |
| msg_type | input | 4 | messageType nibble of that message |
| cfg_sel | input | 2 | Clock-kind select for the mode table |
| cfg_master | input | 1 | Master-role selection |
| cfg_event_only | input | 1 | Restrict to event messages |
| ts_in | input | TS_W | Running timestamp counter value |
| cap_ack | input | 1 | Consumer acknowledge of the held capture |
| cap_vld | output | 1 | Capture register holds an unacknowledged value |
| cap_ts | output | TS_W | Captured timestamp |
| cap_type | output | 4 | Captured message code |
| cap_ovf | output | 1 | A qualifying message was dropped while a capture was held |

## Verification
The hardest situations to reach are those where a strobe and the capture handshake collide. These are a qualifying message against an occupied register, a non-qualifying one in the same spot, and an acknowledge on the same edge as a new qualifying message. The bench first sweeps all 256 combinations of select, role, event-only and message code, acknowledging after each one. It then lines up those collisions by holding back the acknowledge or pulsing it on the exact strobe cycle. After each collision it checks whether the older or the newer timestamp survives.

// File: rtl/ptp_snap_pkg.sv
package ptp_snap_pkg;

  localparam int N_KIND = 7;
  localparam int CODE_W = 4;

  // kind indices inside a capture mask
  localparam int K_SYNC   = 0;
  localparam int K_DREQ   = 1;
  localparam int K_PDREQ  = 2;
  localparam int K_PDRESP = 3;
  localparam int K_FUP    = 4;
  localparam int K_DRESP  = 5;
  localparam int K_PDFUP  = 6;

  typedef logic [N_KIND-1:0] kind_mask_t;

  typedef enum logic [CODE_W-1:0] {
    MT_SYNC   = 4'h0,
    MT_DREQ   = 4'h1,
    MT_PDREQ  = 4'h2,
    MT_PDRESP = 4'h3,
    MT_FUP    = 4'h8,
    MT_DRESP  = 4'h9,
    MT_PDFUP  = 4'hA
  } msg_code_e;

  function automatic logic [CODE_W-1:0] kind_code(input int k);
    case (k)
      K_SYNC:   kind_code = MT_SYNC;
      K_DREQ:   kind_code = MT_DREQ;
      K_PDREQ:  kind_code = MT_PDREQ;
      K_PDRESP: kind_code = MT_PDRESP;
      K_FUP:    kind_code = MT_FUP;
      K_DRESP:  kind_code = MT_DRESP;
      default:  kind_code = MT_PDFUP;
    endcase
  endfunction

endpackage

// File: rtl/ptp_kind_decode.sv
module ptp_kind_decode
  import ptp_snap_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output kind_mask_t        hit
);

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    assign hit[k] = (code == kind_code(k));
  end

endmodule

// File: rtl/ptp_mode_table.sv
module ptp_mode_table
  import ptp_snap_pkg::*;
(
  input  logic [1:0]  sel,
  input  logic        master,
  input  logic        event_only,
  input  kind_mask_t  hit,
  output logic        qualify
);

  kind_mask_t allow;
  kind_mask_t role_evt;

  always_comb begin
    // the one-step event message that belongs to the selected role
    role_evt = '0;
    if (master) role_evt[K_DREQ] = 1'b1;
    else        role_evt[K_SYNC] = 1'b1;

    allow = '0;
    case (sel)
      2'd0: begin
        if (event_only) begin
          allow = role_evt;
        end else begin
          allow[K_SYNC]  = 1'b1;
          allow[K_DREQ]  = 1'b1;
          allow[K_FUP]   = 1'b1;
          allow[K_DRESP] = 1'b1;
        end
      end
      2'd1: begin
        if (event_only) begin
          allow           = role_evt;
          allow[K_PDREQ]  = 1'b1;
          allow[K_PDRESP] = 1'b1;
        end else begin
          allow = '1;
        end
      end
      2'd2: begin
        allow[K_SYNC] = 1'b1;
        allow[K_DREQ] = 1'b1;
      end
      default: begin
        allow[K_PDREQ]  = 1'b1;
        allow[K_PDRESP] = 1'b1;
      end
    endcase
  end

  assign qualify = |(allow & hit);

endmodule

// File: rtl/ptp_snap_capture.sv
module ptp_snap_capture #(
  parameter int TS_W   = 64,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              qualify,
  input  logic [CODE_W-1:0] code,
  input  logic [TS_W-1:0]   ts,
  input  logic              ack,
  output logic              vld,
  output logic [TS_W-1:0]   ts_q,
  output logic [CODE_W-1:0] code_q,
  output logic              ovf
);

  logic vld_d, ovf_d;
  logic pending, take, clash;

  always_comb begin
    pending = vld & ~ack;
    take    = strobe & qualify & ~pending;
    clash   = strobe & qualify &  pending;

    vld_d = vld;
    if (take)     vld_d = 1'b1;
    else if (ack) vld_d = 1'b0;

    ovf_d = ovf;
    if (clash)    ovf_d = 1'b1;
    else if (ack) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      ovf <= 1'b0;
    end else begin
      vld <= vld_d;
      ovf <= ovf_d;
    end
  end

  // payload register, loaded only on an accepted capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q   <= '0;
      code_q <= '0;
    end else if (take) begin
      ts_q   <= ts;
      code_q <= code;
    end
  end

endmodule

// File: rtl/ptp_snap_filter.sv
module ptp_snap_filter
  import ptp_snap_pkg::*;
#(
  parameter int TS_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_vld,
  input  logic [3:0]        msg_type,
  input  logic [1:0]        cfg_sel,
  input  logic              cfg_master,
  input  logic              cfg_event_only,
  input  logic [TS_W-1:0]   ts_in,
  input  logic              cap_ack,
  output logic              cap_vld,
  output logic [TS_W-1:0]   cap_ts,
  output logic [3:0]        cap_type,
  output logic              cap_ovf
);

  kind_mask_t hit;
  logic       qualify;

  ptp_kind_decode u_dec (
    .code (msg_type),
    .hit  (hit)
  );

  ptp_mode_table u_mode (
    .sel        (cfg_sel),
    .master     (cfg_master),
    .event_only (cfg_event_only),
    .hit        (hit),
    .qualify    (qualify)
  );

  ptp_snap_capture #(.TS_W(TS_W), .CODE_W(CODE_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (msg_vld),
    .qualify (qualify),
    .code    (msg_type),
    .ts      (ts_in),
    .ack     (cap_ack),
    .vld     (cap_vld),
    .ts_q    (cap_ts),
    .code_q  (cap_type),
    .ovf     (cap_ovf)
  );

endmodule

// File: rtl/ptp_snap_filter_chk.sv
module ptp_snap_filter_chk #(
  parameter int TS_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            msg_vld,
  input logic [3:0]      msg_type,
  input logic [1:0]      cfg_sel,
  input logic [TS_W-1:0] ts_in,
  input logic            cap_ack,
  input logic            cap_vld,
  input logic [TS_W-1:0] cap_ts,
  input logic [3:0]      cap_type,
  input logic            cap_ovf
);

  // R12
  new_cap_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_vld) |-> $past(msg_vld));

  // R8
  cap_ts_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_vld) |-> (cap_ts == $past(ts_in) && cap_type == $past(msg_type)));

  // R9
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && !cap_ack) |=> (cap_vld && $stable(cap_ts) && $stable(cap_type)));

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && cap_ack && !msg_vld) |=> (!cap_vld && !cap_ovf));

  // R10
  ovf_with_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ovf |-> cap_vld);

  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_ovf) |-> $past(cap_vld && msg_vld && !cap_ack));

  // R6
  sel3_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cap_vld) && $past(cfg_sel) == 2'd3) |-> (cap_type == 4'h2 || cap_type == 4'h3));

  // R7
  cap_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |-> (cap_type <= 4'h3 || (cap_type >= 4'h8 && cap_type <= 4'hA)));

endmodule

bind ptp_snap_filter ptp_snap_filter_chk #(.TS_W(TS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .msg_vld  (msg_vld),
  .msg_type (msg_type),
  .cfg_sel  (cfg_sel),
  .ts_in    (ts_in),
  .cap_ack  (cap_ack),
  .cap_vld  (cap_vld),
  .cap_ts   (cap_ts),
  .cap_type (cap_type),
  .cap_ovf  (cap_ovf)
);

// File: tb/sim_ptp_snap_filter.sv
`timescale 1ns/1ps
module sim_ptp_snap_filter;

  localparam int TS_W = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            msg_vld;
  logic [3:0]      msg_type;
  logic [1:0]      cfg_sel;
  logic            cfg_master;
  logic            cfg_event_only;
  logic [TS_W-1:0] ts_in;
  logic            cap_ack;
  logic            cap_vld;
  logic [TS_W-1:0] cap_ts;
  logic [3:0]      cap_type;
  logic            cap_ovf;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ptp_snap_filter #(.TS_W(TS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .msg_vld(msg_vld), .msg_type(msg_type),
    .cfg_sel(cfg_sel), .cfg_master(cfg_master), .cfg_event_only(cfg_event_only),
    .ts_in(ts_in), .cap_ack(cap_ack), .cap_vld(cap_vld), .cap_ts(cap_ts),
    .cap_type(cap_type), .cap_ovf(cap_ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expectation written per message kind from the requirements
  function automatic bit expect_cap(input int s, input bit m, input bit e, input int t);
    case (t)
      0:       return (s == 2) || (s < 2 && (!e || !m));
      1:       return (s == 2) || (s < 2 && (!e || m));
      2, 3:    return (s == 1) || (s == 3);
      8, 9:    return (s < 2) && !e;
      10:      return (s == 1) && !e;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string mode_tag(input int s, input bit e, input int t);
    if (!((t <= 3) || (t >= 8 && t <= 10))) return "R7";
    if (s == 0) return e ? "R3" : "R2";
    if (s == 1) return e ? "R5" : "R4";
    return "R6";
  endfunction

  task automatic strobe(input logic [3:0] t, input logic [TS_W-1:0] ts, input bit ack);
    @(negedge clk);
    msg_vld  = 1'b1;
    msg_type = t;
    ts_in    = ts;
    cap_ack  = ack;
    @(negedge clk);
    msg_vld = 1'b0;
    cap_ack = 1'b0;
    ts_in   = ~ts;
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    cap_ack = 1'b1;
    @(negedge clk);
    cap_ack = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [TS_W-1:0] tsv;
    rst_n = 1'b0; msg_vld = 0; msg_type = 0; cfg_sel = 0; cfg_master = 0;
    cfg_event_only = 0; ts_in = '0; cap_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!cap_vld, "R1 vld", cap_vld, 0);
    chk(!cap_ovf, "R1 ovf", cap_ovf, 0);

    // full sweep of the mode table and all codes
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 2; m++)
        for (int e = 0; e < 2; e++)
          for (int t = 0; t < 16; t++) begin
            bit ex;
            string tag;
            ex  = expect_cap(s, m[0], e[0], t);
            tag = mode_tag(s, e[0], t);
            tsv = 64'h1000_0000_0000 + 64'(s * 4096 + m * 512 + e * 64 + t) * 64'd37;
            @(negedge clk);
            cfg_sel = 2'(s); cfg_master = m[0]; cfg_event_only = e[0];
            strobe(4'(t), tsv, 1'b0);
            chk(cap_vld == ex, tag, cap_vld, ex);
            if (ex) begin
              chk(cap_ts == tsv, "R8 ts", cap_ts, tsv);
              chk(cap_type == 4'(t), "R8 type", cap_type, t);
              chk(!cap_ovf, "R10 no ovf", cap_ovf, 0);
              ack_pulse();
              chk(!cap_vld, "R9 ack clears", cap_vld, 0);
            end
          end

    // R12: qualifying configuration present but no strobe
    cfg_sel = 2'd2; msg_type = 4'h0;
    repeat (4) @(negedge clk);
    chk(!cap_vld, "R12 no strobe", cap_vld, 0);

    // R10: pending capture, then non-qualifying and qualifying strobes
    strobe(4'h0, 64'hAAAA_0001, 1'b0);
    chk(cap_vld && cap_ts == 64'hAAAA_0001, "R8 first", cap_ts, 64'hAAAA_0001);
    strobe(4'h9, 64'hBBBB_0002, 1'b0);
    chk(!cap_ovf, "R10 nonqual keeps ovf", cap_ovf, 0);
    // R12: config moves while pending, capture unaffected
    cfg_sel = 2'd3;
    @(negedge clk);
    chk(cap_vld && cap_type == 4'h0, "R12 cfg change", cap_type, 0);
    cfg_sel = 2'd2;
    strobe(4'h1, 64'hCCCC_0003, 1'b0);
    chk(cap_ovf == 1'b1, "R10 ovf set", cap_ovf, 1);
    chk(cap_ts == 64'hAAAA_0001, "R10 old ts kept", cap_ts, 64'hAAAA_0001);
    chk(cap_type == 4'h0, "R10 old type kept", cap_type, 0);
    repeat (3) @(negedge clk);
    chk(cap_vld && cap_ovf && cap_ts == 64'hAAAA_0001, "R9 hold", cap_ts, 64'hAAAA_0001);
    ack_pulse();
    chk(!cap_vld, "R9 vld clr", cap_vld, 0);
    chk(!cap_ovf, "R9 ovf clr", cap_ovf, 0);

    // R11: ack coincides with a new qualifying strobe
    strobe(4'h0, 64'hDDDD_0004, 1'b0);
    strobe(4'h1, 64'hEEEE_0005, 1'b1);
    chk(cap_vld, "R11 vld", cap_vld, 1);
    chk(cap_ts == 64'hEEEE_0005, "R11 new ts", cap_ts, 64'hEEEE_0005);
    chk(cap_type == 4'h1, "R11 new type", cap_type, 1);
    chk(!cap_ovf, "R11 ovf low", cap_ovf, 0);
    ack_pulse();

    // R1: reset in the middle of a held capture with overflow
    strobe(4'h0, 64'h1, 1'b0);
    strobe(4'h0, 64'h2, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!cap_vld && !cap_ovf, "R1 reset again", {cap_vld, cap_ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule